// File: doc/BRIEF.md
# Dual-Read Program Register Bank

This block holds the program-visible working registers of a small processor core: a bank of eight words, 32 bits each, reached through two read ports and one write port. Every port is addressed by a 4-bit register selector. The two read ports are combinational. A selector presented at any time produces the stored word on that port's data output within the same cycle. The write port captures its selector and word on each rising clock edge.

The bank has no enable pins. Selector values 0 to 7 name a real register. Every selector from 8 to 15 is a null selector: it names no register. A read port given a null selector returns zero. A write given a null selector changes nothing. Pipeline stages with no operand to fetch, or no result to retire, therefore drive the value 8 and need no extra wiring.

Data moves through plain selector and data pins with no valid/ready handshake. A read answers in the same cycle and a write completes at the next edge, so there is never a reason to apply back-pressure.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers are set to zero. Afterwards, every selector from 0 to 7 reads back 0 on both ports.
- R2: At a rising edge with `rst` low and `wr_sel` between 0 and 7, register `wr_sel` takes the value on `wr_data`. No other register changes.
- R3: `rd_a_data` equals the stored contents of register `rd_a_sel` within the same cycle, for any `rd_a_sel` from 0 to 7.
- R4: Read port B (`rd_b_sel`, `rd_b_data`) works independently of port A. Both ports may select the same register or different registers while a write occurs in the same cycle.
- R5: A write with `wr_sel` equal to 8 leaves all eight registers unchanged.
- R6: A write with `wr_sel` from 9 to 15 also leaves all eight registers unchanged.
- R7: A read port whose selector is 8 to 15 outputs 0.
- R8: During the cycle in which a register is being written, a read of that register returns its previous value. The new value appears after the edge.
- R9: Reset takes priority over a write in the same cycle: the addressed register ends up zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 4 | Read port A selector (8 to 15 = null) |
| rd_a_data | output | 32 | Read port A word |
| rd_b_sel | input | 4 | Read port B selector (8 to 15 = null) |
| rd_b_data | output | 32 | Read port B word |
| wr_sel | input | 4 | Write selector (8 to 15 = null, no write) |
| wr_data | input | 32 | Word to be written |

## Verification
The bench targets the edges of the selector space:
- Selector 8, which is the canonical null code. A decoder that compared only the low three bits would alias it onto register 0.
- Selectors 9 and 15. A design that matched only the single value 8 as null would corrupt a register on these.
- A read of a register in the same cycle it is written. This exposes a read path that forwards the new word early, and it also exposes a write that lands one cycle late.
- Reset held during a write. A design that let the write win would leave a nonzero word behind.
- Both ports on the same register, and on different registers, in the same cycle. This catches ports that share or swap their muxes.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Selector width and bank depth shared by the submodules.
  localparam int unsigned GPR_SEL_W  = 4;
  localparam int unsigned GPR_DEPTH  = 8;
  localparam int unsigned GPR_WORD_W = 32;

  // A selector names a real register only below the bank depth.
  function automatic logic sel_live(input logic [GPR_SEL_W-1:0] sel,
                                    input int unsigned depth);
    return (32'(sel) < depth);
  endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned SEL_W = gpr_pkg::GPR_SEL_W,
  parameter int unsigned DEPTH = gpr_pkg::GPR_DEPTH
) (
  input  logic [SEL_W-1:0] wr_sel,
  output logic [DEPTH-1:0] wr_hit
);

  // One comparator per register; null codes match none of them.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign wr_hit[g] = (wr_sel == SEL_W'(g));
  end

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned WORD_W = gpr_pkg::GPR_WORD_W,
  parameter int unsigned DEPTH  = gpr_pkg::GPR_DEPTH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DEPTH-1:0]             wr_hit,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [DEPTH-1:0][WORD_W-1:0] cells
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)            cells[g] <= '0;
      else if (wr_hit[g]) cells[g] <= wr_data;
    end

    // R1
    clear_on_reset_chk: assert property (@(posedge clk)
      rst |=> cells[g] == '0);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] |=> cells[g] == $past(wr_data));

    // R2
    untouched_holds_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[g] |=> $stable(cells[g]));
  end

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int unsigned SEL_W  = gpr_pkg::GPR_SEL_W,
  parameter int unsigned WORD_W = gpr_pkg::GPR_WORD_W,
  parameter int unsigned DEPTH  = gpr_pkg::GPR_DEPTH
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] cells,
  input  logic [SEL_W-1:0]             sel,
  output logic [WORD_W-1:0]            data
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             live;
  logic [IDX_W-1:0] idx;

  assign live = gpr_pkg::sel_live(sel, DEPTH);
  assign idx  = IDX_W'(sel);

  always_comb begin
    data = '0;
    if (live) data = cells[idx];
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned SEL_W  = gpr_pkg::GPR_SEL_W,
  parameter int unsigned WORD_W = gpr_pkg::GPR_WORD_W,
  parameter int unsigned DEPTH  = gpr_pkg::GPR_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rd_a_sel,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic [SEL_W-1:0]  rd_b_sel,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data
);

  logic [DEPTH-1:0]             wr_hit;
  logic [DEPTH-1:0][WORD_W-1:0] cells;

  gpr_wr_decode #(.SEL_W(SEL_W), .DEPTH(DEPTH)) u_dec (
    .wr_sel (wr_sel),
    .wr_hit (wr_hit)
  );

  gpr_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_data (wr_data),
    .cells   (cells)
  );

  gpr_rd_port #(.SEL_W(SEL_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_rd_a (
    .cells (cells),
    .sel   (rd_a_sel),
    .data  (rd_a_data)
  );

  gpr_rd_port #(.SEL_W(SEL_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_rd_b (
    .cells (cells),
    .sel   (rd_b_sel),
    .data  (rd_b_data)
  );

  // R5 R6
  null_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    !gpr_pkg::sel_live(wr_sel, DEPTH) |=> $stable(cells));

  // R5 R6
  null_write_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !gpr_pkg::sel_live(wr_sel, DEPTH) |-> wr_hit == '0);

  // R4
  ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_sel == rd_b_sel) |-> (rd_a_data == rd_b_data));

  // R7
  null_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !gpr_pkg::sel_live(rd_a_sel, DEPTH) |-> rd_a_data == '0);

endmodule

// File: tb/gpr_bank_test.sv
module gpr_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 4 + 32 + 4 + 4 + 32 + 32;
  localparam int NVEC = 9;

  // {wr_sel, wr_data, rd_a_sel, rd_b_sel, expect_a, expect_b}; expectations sampled before the edge
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {4'd1,  32'h11111111, 4'd1,  4'd2,  32'h00000000, 32'h00000000},
    {4'd2,  32'h22222222, 4'd1,  4'd2,  32'h11111111, 32'h00000000},
    {4'd8,  32'hDEADBEEF, 4'd1,  4'd2,  32'h11111111, 32'h22222222},
    {4'd15, 32'hCAFEF00D, 4'd1,  4'd2,  32'h11111111, 32'h22222222},
    {4'd7,  32'h77777777, 4'd8,  4'd1,  32'h00000000, 32'h11111111},
    {4'd0,  32'hA5A5A5A5, 4'd7,  4'd12, 32'h77777777, 32'h00000000},
    {4'd1,  32'h01010101, 4'd0,  4'd0,  32'hA5A5A5A5, 32'hA5A5A5A5},
    {4'd9,  32'hFFFFFFFF, 4'd1,  4'd7,  32'h01010101, 32'h77777777},
    {4'd8,  32'h00000000, 4'd2,  4'd9,  32'h22222222, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = 4'd8;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_bank uut (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_sel(wr_sel), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive after the falling edge; sample a little later, still before the rising edge.
  task automatic step(input logic [3:0] ws, input logic [31:0] wd,
                      input logic [3:0] as, input logic [3:0] bs);
    @(negedge clk);
    wr_sel = ws; wr_data = wd; rd_a_sel = as; rd_b_sel = bs;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state on both ports
    for (int i = 0; i < 8; i++) begin
      step(4'd8, 32'h0, 4'(i), 4'(7 - i));
      check("R1 port A", rd_a_data, 32'h0);
      check("R1 port B", rd_b_data, 32'h0);
    end

    // Table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      step(VECS[v][107:104], VECS[v][103:72], VECS[v][71:68], VECS[v][67:64]);
      check("R3/R8 port A", rd_a_data, VECS[v][63:32]);
      check("R4/R8 port B", rd_b_data, VECS[v][31:0]);
    end

    // R2 fill every register, then read all back on both ports
    for (int i = 0; i < 8; i++) step(4'(i), 32'h1000_0000 + 32'(i) * 32'h0101, 4'd8, 4'd8);
    for (int i = 0; i < 8; i++) begin
      step(4'd8, 32'hBAD0BAD0, 4'(i), 4'(7 - i));
      check("R2 port A", rd_a_data, 32'h1000_0000 + 32'(i) * 32'h0101);
      check("R4 port B", rd_b_data, 32'h1000_0000 + 32'(7 - i) * 32'h0101);
    end

    // R7 every null selector reads zero
    for (int s = 8; s < 16; s++) begin
      step(4'd8, 32'h0, 4'(s), 4'(s));
      check("R7 port A", rd_a_data, 32'h0);
      check("R7 port B", rd_b_data, 32'h0);
    end

    // R6 sweep writes with 9..15, then confirm the bank is intact
    for (int s = 9; s < 16; s++) step(4'(s), 32'hEEEE0000 + 32'(s), 4'd8, 4'd8);
    for (int i = 0; i < 8; i++) begin
      step(4'd8, 32'h0, 4'(i), 4'(i));
      check("R6 port A", rd_a_data, 32'h1000_0000 + 32'(i) * 32'h0101);
    end

    // R8 same-cycle read shows old, next cycle shows new
    step(4'd5, 32'h55AA55AA, 4'd5, 4'd5);
    check("R8 old A", rd_a_data, 32'h1000_0505);
    check("R8 old B", rd_b_data, 32'h1000_0505);
    step(4'd8, 32'h0, 4'd5, 4'd4);
    check("R8 new A", rd_a_data, 32'h55AA55AA);
    check("R4 other B", rd_b_data, 32'h1000_0404);

    // R9 reset together with a write: reset wins
    @(negedge clk);
    rst = 1'b1; wr_sel = 4'd3; wr_data = 32'h33333333;
    @(negedge clk);
    rst = 1'b0; wr_sel = 4'd8;
    for (int i = 0; i < 8; i++) begin
      step(4'd8, 32'h0, 4'(i), 4'd3);
      check("R9/R1 port A", rd_a_data, 32'h0);
      check("R9 port B", rd_b_data, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule